// File: doc/BRIEF.md
# Burst Read Wait-State Controller

This block sequences the read latency on the device side of a synchronous burst memory port. The host lowers the address strobe for one cycle together with a start address. The controller then waits a programmable number of clock cycles before it presents the first word. It raises a ready indication, presents one word per clock from a stepping burst address, and stalls for one cycle at each address boundary when that option is enabled. The host ends a burst with a one-cycle terminate pulse. A new strobe edge restarts the burst at a new address.

Three configuration fields set this behaviour: a 3-bit latency code, a boundary-wait enable and a full-rate clocking bit. The host writes them through a one-cycle write strobe. A write that arrives while a burst runs is parked and applied once the controller is idle. A write that carries a reserved latency code is refused and sets a sticky error flag. The memory array is modelled as a fixed function of the address.

The read data output is a valid-only stream. `dvalid` marks each word, and the host cannot apply back-pressure: the host must take every word in the cycle in which `dvalid` is high, and it stops the burst with `term`. `rdy` is the early form of that valid, meant for a host that needs a cycle of warning.

Top module: `burst_wait_seq`

## Requirements
- R1: After `rst_n` is low, `lat_code` reads 3'b101 (7 cycles), `xwait_en` reads 1, `fullclk_en` reads 1, `cfg_err` reads 0, and `busy`, `dvalid` and `rdy` read 0.
- R2: A burst starts on the rising edge that samples `adv_n` low after a high sample. With latency code c, the latency is L = c+2. The first `dvalid` appears after the L-th rising edge, counting the starting edge as the first.
- R3: For L > 2, `rdy` is high in the cycle just before the first data word, and in every cycle in which `dvalid` is high.
- R4: For L = 2 (code 3'b000), `rdy` is low before the first word and stays equal to `dvalid`.
- R5: The first word has `burst_addr` equal to `start_addr`. Each later word has the address one higher. `dout` equals `burst_addr` XOR `SEED` (default 16'hC3A5).
- R6: When `xwait_en` is 1 and the next burst address has its low log2(`BND_WORDS`) bits all zero (default 4 bits), one cycle with `dvalid` and `rdy` both low falls between the two words. When `xwait_en` is 0, no such cycle appears.
- R7: Applying latency code 3'b110 or 3'b111 leaves `lat_code` unchanged and sets `cfg_err`, while the other two fields still take the written values. `cfg_err` stays 1 until reset.
- R8: A write made while `busy` is high does not change the fields during the burst. The last such write takes effect on the first edge at which `busy` is low.
- R9: A write made in the same cycle as the starting strobe while idle is applied at that edge. The starting burst uses the previous latency.
- R10: A new starting strobe during a burst restarts the full latency count from the new address. It takes priority over the latency count expiring at the same edge.
- R11: `term` high at an edge during a burst returns the block to idle: `busy` and `dvalid` are 0 in the next cycle.
- R12: `fullclk_en` holds the last accepted value of `cfg_fullclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| adv_n | input | 1 | Address strobe, active low; a high-to-low sample starts a burst |
| start_addr | input | AW | Burst start address, taken with the strobe |
| term | input | 1 | One-cycle burst terminate |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_lat | input | 3 | Latency code to write |
| cfg_xwait | input | 1 | Boundary-wait enable to write |
| cfg_fullclk | input | 1 | Full-rate clock bit to write |
| rdy | output | 1 | Ready: one cycle early for L > 2, with data for L = 2 |
| dvalid | output | 1 | Data word valid |
| dout | output | DW | Data word |
| burst_addr | output | AW | Current burst address |
| busy | output | 1 | Burst in progress |
| lat_code | output | 3 | Current latency code |
| xwait_en | output | 1 | Current boundary-wait enable |
| fullclk_en | output | 1 | Current full-rate bit |
| cfg_err | output | 1 | Sticky reserved-code error |

## Verification
A configuration write and a starting strobe can land on the same idle edge. The bench drives both in one cycle and checks two things: the new latency code is visible the cycle after, and the first word still arrives after the old latency. A restart strobe can also coincide with the last cycle of a latency count. The bench times a second strobe onto exactly that edge and judges the result by the new burst's latency and address, with no stray word from the first burst in the scoreboard.

// File: rtl/bws_pkg.sv
package bws_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LAT, ST_DATA, ST_GAP} seq_state_t;

  // total initial access cycles for a latency code
  function automatic logic [2:0] lat_cycles(input logic [2:0] code);
    return code + 3'd2;
  endfunction

  function automatic logic code_reserved(input logic [2:0] code);
    return code[2] & code[1];
  endfunction
endpackage

// File: rtl/bws_cfg.sv
module bws_cfg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       cfg_wr,
  input  logic [2:0] cfg_lat,
  input  logic       cfg_xwait,
  input  logic       cfg_fullclk,
  output logic [2:0] lat_code,
  output logic       xwait_en,
  output logic       fullclk_en,
  output logic       cfg_err
);
  import bws_pkg::*;

  logic       pend_v;
  logic [2:0] pend_lat;
  logic       pend_xw, pend_fc;
  logic       apply;
  logic [2:0] sel_lat;
  logic       sel_xw, sel_fc;

  always_comb begin
    apply   = !busy && (cfg_wr || pend_v);
    sel_lat = cfg_wr ? cfg_lat     : pend_lat;
    sel_xw  = cfg_wr ? cfg_xwait   : pend_xw;
    sel_fc  = cfg_wr ? cfg_fullclk : pend_fc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_code   <= 3'b101;
      xwait_en   <= 1'b1;
      fullclk_en <= 1'b1;
      cfg_err    <= 1'b0;
      pend_v     <= 1'b0;
      pend_lat   <= 3'b101;
      pend_xw    <= 1'b1;
      pend_fc    <= 1'b1;
    end else if (cfg_wr && busy) begin
      pend_v   <= 1'b1;
      pend_lat <= cfg_lat;
      pend_xw  <= cfg_xwait;
      pend_fc  <= cfg_fullclk;
    end else if (apply) begin
      pend_v     <= 1'b0;
      xwait_en   <= sel_xw;
      fullclk_en <= sel_fc;
      if (code_reserved(sel_lat)) cfg_err  <= 1'b1;
      else                        lat_code <= sel_lat;
    end
  end
endmodule

// File: rtl/bws_core.sv
module bws_core #(
  parameter int AW        = 16,
  parameter int BND_WORDS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_n,
  input  logic [AW-1:0] start_addr,
  input  logic          term,
  input  logic [2:0]    lat_code,
  input  logic          xwait_en,
  output logic          rdy,
  output logic          dvalid,
  output logic          busy,
  output logic [AW-1:0] burst_addr
);
  import bws_pkg::*;

  localparam int BW = $clog2(BND_WORDS);

  seq_state_t    st;
  logic [2:0]    cnt;
  logic          adv_q, two_cyc, start, at_bnd;
  logic [AW-1:0] nxt;

  always_comb begin
    start  = !adv_n && adv_q;
    nxt    = burst_addr + AW'(1);
    at_bnd = (nxt[BW-1:0] == '0);
    dvalid = (st == ST_DATA);
    busy   = (st != ST_IDLE);
    rdy    = (st == ST_DATA) || (st == ST_LAT && cnt == 3'd1 && !two_cyc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      adv_q      <= 1'b1;
      two_cyc    <= 1'b0;
      burst_addr <= '0;
    end else begin
      adv_q <= adv_n;
      if (start) begin
        st         <= ST_LAT;
        cnt        <= lat_cycles(lat_code) - 3'd1;
        two_cyc    <= (lat_code == 3'b000);
        burst_addr <= start_addr;
      end else if (term && st != ST_IDLE) begin
        st <= ST_IDLE;
      end else begin
        case (st)
          ST_LAT: begin
            if (cnt == 3'd1) st <= ST_DATA;
            else             cnt <= cnt - 3'd1;
          end
          ST_DATA: begin
            burst_addr <= nxt;
            if (xwait_en && at_bnd) st <= ST_GAP;
          end
          ST_GAP:  st <= ST_DATA;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/bws_array.sv
module bws_array #(
  parameter int              AW   = 16,
  parameter int              DW   = 16,
  parameter logic [DW-1:0]   SEED = 16'hC3A5
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  assign data = DW'(addr) ^ SEED;
endmodule

// File: rtl/burst_wait_seq.sv
module burst_wait_seq #(
  parameter int            AW        = 16,
  parameter int            DW        = 16,
  parameter int            BND_WORDS = 16,
  parameter logic [DW-1:0] SEED      = 16'hC3A5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_n,
  input  logic [AW-1:0] start_addr,
  input  logic          term,
  input  logic          cfg_wr,
  input  logic [2:0]    cfg_lat,
  input  logic          cfg_xwait,
  input  logic          cfg_fullclk,
  output logic          rdy,
  output logic          dvalid,
  output logic [DW-1:0] dout,
  output logic [AW-1:0] burst_addr,
  output logic          busy,
  output logic [2:0]    lat_code,
  output logic          xwait_en,
  output logic          fullclk_en,
  output logic          cfg_err
);
  bws_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .cfg_wr(cfg_wr), .cfg_lat(cfg_lat), .cfg_xwait(cfg_xwait), .cfg_fullclk(cfg_fullclk),
    .lat_code(lat_code), .xwait_en(xwait_en), .fullclk_en(fullclk_en), .cfg_err(cfg_err)
  );

  bws_core #(.AW(AW), .BND_WORDS(BND_WORDS)) u_core (
    .clk(clk), .rst_n(rst_n), .adv_n(adv_n), .start_addr(start_addr), .term(term),
    .lat_code(lat_code), .xwait_en(xwait_en),
    .rdy(rdy), .dvalid(dvalid), .busy(busy), .burst_addr(burst_addr)
  );

  bws_array #(.AW(AW), .DW(DW), .SEED(SEED)) u_arr (
    .addr(burst_addr), .data(dout)
  );
endmodule

// File: rtl/bws_checker.sv
module bws_checker #(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int BND_WORDS = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adv_n,
  input logic          term,
  input logic          rdy,
  input logic          dvalid,
  input logic [DW-1:0] dout,
  input logic [AW-1:0] burst_addr,
  input logic          busy,
  input logic [2:0]    lat_code,
  input logic          xwait_en,
  input logic          cfg_err
);
  localparam int BW = $clog2(BND_WORDS);
  logic [AW-1:0] nxt_a;
  assign nxt_a = burst_addr + AW'(1);

  a_r3_valid_has_ready: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid |-> rdy);

  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dvalid && adv_n && !term) |=> (burst_addr == $past(nxt_a)));

  a_r6_gap_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (dvalid && adv_n && !term && xwait_en && nxt_a[BW-1:0] == '0) |=> (!dvalid && !rdy));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  a_r7_no_reserved_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(lat_code[2] && lat_code[1]));

  a_r8_cfg_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(lat_code));

  a_r11_term_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (term && adv_n && busy) |=> (!busy && !dvalid));
endmodule

bind burst_wait_seq bws_checker #(.AW(AW), .DW(DW), .BND_WORDS(BND_WORDS)) u_chk (.*);

// File: tb/sim_burst_wait_seq.sv
module sim_burst_wait_seq;
  localparam logic [15:0] SEED = 16'hC3A5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv_n = 1'b1;
  logic [15:0] start_addr = '0;
  logic        term = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_lat = 3'b101;
  logic        cfg_xwait = 1'b1;
  logic        cfg_fullclk = 1'b1;
  logic        rdy, dvalid, busy, xwait_en, fullclk_en, cfg_err;
  logic [15:0] dout, burst_addr;
  logic [2:0]  lat_code;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] expq[$];

  always #10 clk = ~clk;

  burst_wait_seq u0 (
    .clk(clk), .rst_n(rst_n), .adv_n(adv_n), .start_addr(start_addr), .term(term),
    .cfg_wr(cfg_wr), .cfg_lat(cfg_lat), .cfg_xwait(cfg_xwait), .cfg_fullclk(cfg_fullclk),
    .rdy(rdy), .dvalid(dvalid), .dout(dout), .burst_addr(burst_addr), .busy(busy),
    .lat_code(lat_code), .xwait_en(xwait_en), .fullclk_en(fullclk_en), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && dvalid) begin
      if (expq.size() == 0) chk(1'b0, "R5", "unexpected word at addr", int'(burst_addr), -1);
      else begin
        logic [15:0] ea;
        ea = expq.pop_front();
        chk(burst_addr == ea, "R5", "burst address", int'(burst_addr), int'(ea));
        chk(dout == (ea ^ SEED), "R5", "data word", int'(dout), int'(ea ^ SEED));
      end
    end
  end

  task automatic wr_cfg(input logic [2:0] code, input logic xw, input logic fc);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_lat = code; cfg_xwait = xw; cfg_fullclk = fc;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; adv_n = 1'b1; term = 1'b0; cfg_wr = 1'b0;
    repeat (2) @(negedge clk);
    expq.delete();
    chk(lat_code == 3'b101, "R1", "lat_code", int'(lat_code), 5);
    chk(xwait_en && fullclk_en, "R1", "xwait/fullclk", int'({xwait_en, fullclk_en}), 3);
    chk(!cfg_err, "R1", "cfg_err", int'(cfg_err), 0);
    chk(!busy && !dvalid && !rdy, "R1", "idle outputs", int'({busy, dvalid, rdy}), 0);
    rst_n = 1'b1;
  endtask

  task automatic run_burst(input logic [15:0] a, input int L, input bit xw, input int nw,
                           input bit same_wr, input logic [2:0] same_code,
                           input bit mid_wr, input logic [2:0] mid_code, input logic [2:0] hold_code);
    int j, cnt, gaps, exp_gaps, guard;
    logic [15:0] na;
    @(negedge clk);
    adv_n = 1'b0; start_addr = a;
    if (same_wr) begin cfg_wr = 1'b1; cfg_lat = same_code; end
    exp_gaps = 0;
    for (int i = 0; i < nw; i++) begin
      expq.push_back(a + 16'(i));
      na = a + 16'(i);
      if (i > 0 && xw && na[3:0] == 4'h0) exp_gaps++;
    end
    @(negedge clk);
    adv_n = 1'b1; cfg_wr = 1'b0;
    if (same_wr) chk(lat_code == same_code, "R9", "write applied with strobe", int'(lat_code), int'(same_code));
    j = 1;
    while (!dvalid && j < 20) begin
      if (j == L - 1) begin
        if (L > 2) chk(rdy == 1'b1, "R3", "rdy one cycle early", int'(rdy), 1);
        else       chk(rdy == 1'b0, "R4", "rdy not early at L=2", int'(rdy), 0);
      end
      if (mid_wr && j == 1) begin cfg_wr = 1'b1; cfg_lat = 3'b100; end
      if (mid_wr && j == 2) begin
        cfg_lat = mid_code;
        chk(lat_code == hold_code, "R8", "frozen during burst", int'(lat_code), int'(hold_code));
      end
      if (mid_wr && j == 3) begin
        cfg_wr = 1'b0;
        chk(lat_code == hold_code, "R8", "frozen during burst", int'(lat_code), int'(hold_code));
      end
      @(negedge clk);
      j++;
    end
    chk(j == L, "R2", "first data cycle", j, L);
    cnt = 0; gaps = 0; guard = 0;
    while (cnt < nw && guard < 200) begin
      guard++;
      if (dvalid) begin
        chk(rdy == 1'b1, (L > 2) ? "R3" : "R4", "rdy with data", int'(rdy), 1);
        cnt++;
        if (cnt == nw) term = 1'b1;
      end else begin
        na = a + 16'(cnt);
        gaps++;
        chk(xw && na[3:0] == 4'h0 && !rdy, "R6", "wait cycle only at boundary", int'(na), -1);
      end
      @(negedge clk);
      term = 1'b0;
    end
    chk(!dvalid && !busy, "R11", "idle after term", int'({busy, dvalid}), 0);
    chk(gaps == exp_gaps, "R6", "boundary wait count", gaps, exp_gaps);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R2 default latency, no crossing
    run_burst(16'h0010, 7, 1, 4, 0, 3'b000, 0, 3'b000, 3'b000);
    // R6 crossing with boundary wait enabled
    run_burst(16'h001D, 7, 1, 6, 0, 3'b000, 0, 3'b000, 3'b000);
    // R12 and R6 disabled, latency code 010
    wr_cfg(3'b010, 1'b0, 1'b0);
    chk(lat_code == 3'b010, "R2", "lat write", int'(lat_code), 2);
    chk(!xwait_en, "R6", "xwait cleared", int'(xwait_en), 0);
    chk(!fullclk_en, "R12", "fullclk cleared", int'(fullclk_en), 0);
    run_burst(16'h002E, 4, 0, 5, 0, 3'b000, 0, 3'b000, 3'b000);
    // R4 two-cycle latency with a crossing
    wr_cfg(3'b000, 1'b1, 1'b1);
    chk(fullclk_en, "R12", "fullclk set", int'(fullclk_en), 1);
    run_burst(16'h003F, 2, 1, 4, 0, 3'b000, 0, 3'b000, 3'b000);
    // R7 reserved code
    wr_cfg(3'b111, 1'b1, 1'b0);
    chk(lat_code == 3'b000, "R7", "reserved refused", int'(lat_code), 0);
    chk(cfg_err, "R7", "error raised", int'(cfg_err), 1);
    chk(!fullclk_en, "R7", "other field applied", int'(fullclk_en), 0);
    wr_cfg(3'b011, 1'b1, 1'b1);
    chk(lat_code == 3'b011 && cfg_err, "R7", "sticky error after good write", int'({cfg_err, lat_code}), 11);
    run_burst(16'h0100, 5, 1, 3, 0, 3'b000, 0, 3'b000, 3'b000);
    // R8 deferred write, last wins
    wr_cfg(3'b101, 1'b1, 1'b1);
    run_burst(16'h0200, 7, 1, 3, 0, 3'b000, 1, 3'b001, 3'b101);
    chk(lat_code == 3'b101, "R8", "not applied before idle edge", int'(lat_code), 5);
    @(negedge clk);
    chk(lat_code == 3'b001, "R8", "last pending write applied", int'(lat_code), 1);
    run_burst(16'h1234, 3, 1, 3, 0, 3'b000, 0, 3'b000, 3'b000);
    // R9 write with strobe: old latency (3) used
    run_burst(16'h0300, 3, 1, 2, 1, 3'b010, 0, 3'b000, 3'b000);
    // R10 restart on the edge where the first latency would expire (L=4)
    @(negedge clk); adv_n = 1'b0; start_addr = 16'h0400;
    @(negedge clk); adv_n = 1'b1;
    @(negedge clk);
    chk(!dvalid && busy, "R10", "first burst waiting", int'({busy, dvalid}), 2);
    run_burst(16'h0500, 4, 1, 3, 0, 3'b000, 0, 3'b000, 3'b000);
    chk(expq.size() == 0, "R10", "scoreboard drained", expq.size(), 0);
    // R1 hardware reset mid-burst restores defaults
    @(negedge clk); adv_n = 1'b0; start_addr = 16'h0600;
    @(negedge clk); adv_n = 1'b1;
    do_reset();
    run_burst(16'h0700, 7, 1, 2, 0, 3'b000, 0, 3'b000, 3'b000);
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule